// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block carries out a compact-ISA frame-save or frame-restore instruction one memory word at a time. The core hands it a decoded 16-bit instruction, an optional 16-bit extension prefix and the current stack pointer, then pulses `start`. The sequencer reads registers through a combinational register-file read port and issues one 32-bit store per selected register. For a restore it issues one 32-bit load per register instead, sign-extends the loaded word and writes it back. As its last action it writes the adjusted stack pointer into r29.

The set of registers, their order and their addresses are all decoded from packed fields. The return address and the s0/s1 pair come from a 3-bit select field. The prefix adds a count of extra callee-saved registers and a 4-bit argument code. That code splits r4..r7 between argument-area stores above the stack pointer and "static" pushes below it. The frame size comes from a 4-bit field, which the prefix widens to 8 bits.

A memory transaction is held until `mem_ready`. `busy` covers the whole operation and `done` pulses once at the end. The reserved argument code 15 is refused: the block raises `err` and makes no memory access.

Top module: `stack_frame_seq`

## Requirements
- R1: In the 16-bit form (`ext`=0), the instruction layout is bit 7 = 1 for save and 0 for restore, bits 6:4 = register select, and bits 3:0 = frame field F. In the select field, bit 2 selects r31, bit 1 selects r16 and bit 0 selects r17. The frame size is 128 bytes when F=0 and 8*F otherwise. No extra registers and no argument registers take part.
- R2: In the extended form (`ext`=1), the prefix holds the extra-register count X in bits 10:8, the high frame bits in 7:4 and the argument code A in 3:0. The frame size is 8*({high,F}), and a value of 0 gives a frame of 0 bytes.
- R3: A maps to an argument count and a static count as follows. Argument count: 0 for A in {0,1,2,3,11}, 1 for A in 4..7, 2 for A in 8..10, 3 for A in {12,13} and 4 for A=14. Static count: 0 for A in {0,4,8,12,14}, 1 for A in {1,5,9,13}, 2 for A in {2,6,10}, 3 for A in {3,7} and 4 for A=11.
- R4: A save first stores r4, r5, ... (as many as the argument count) at SP+0, SP+4, SP+8 and SP+12.
- R5: After the argument stores, each save store goes to a running address that starts at SP and drops by 4 before every access. The order is r31 (if selected), then r30 (only when X=7), then r23 down through r18 (X registers in all, counting r30), then r17, then r16, then r7, r6, r5, r4 (as many as the static count). The low 32 bits of each register are stored.
- R6: After a save, r29 is written with SP minus the frame size, one cycle after the last store is accepted.
- R7: A restore makes no argument-area accesses. Its running address starts at SP plus the frame size and drops by 4 before each load, following the same register order as R5. Each loaded word is sign-extended into its register in the cycle it is accepted. Finally r29 is written with SP plus the frame size.
- R8: At most one memory request is outstanding. While `mem_ready` is low, `mem_req`, `mem_addr` and `mem_we` hold their values.
- R9: `busy` rises the cycle after an accepted `start` and stays high until the operation ends. `done` is a one-cycle pulse in the cycle `busy` falls. `mem_req` and `rf_we` are active only while `busy` is high.
- R10: An extended instruction with A=15 makes no memory request and no register write, so SP is unchanged. It pulses `done` together with `err` in the cycle after `start`. `err` is never high without `done`.
- R11: After reset, `busy`, `done`, `err`, `mem_req` and `rf_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; sampled while idle |
| ext | input | 1 | Extension prefix is valid |
| prefix | input | 16 | Extension prefix word |
| insn | input | 16 | Save/restore instruction word |
| sp_in | input | XLEN | Current stack pointer |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | XLEN | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | XLEN | Register-file write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | XLEN | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Reserved argument code seen (with `done`) |

## Verification
Directed cases come first. A 16-bit save with frame field 0 and all three select bits shows the 128-byte frame and the r31-r17-r16 order. An extended save with X=7 and A=11 exercises r30 and four static pushes. A=14 exercises four argument-area stores without any running-address motion, and A=15 checks the refusal path. Restores with data whose bit 31 alternates separate sign extension from zero extension. Random field combinations under random `mem_ready` stalls then compare every address, direction, data word and final stack pointer against a trace built in the bench from the field tables.

// File: rtl/stack_frame_seq.sv
module stack_frame_seq #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ext,
  input  logic [15:0]     prefix,
  input  logic [15:0]     insn,
  input  logic [XLEN-1:0] sp_in,
  output logic [4:0]      rf_raddr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            rf_we,
  output logic [4:0]      rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ready,
  output logic            busy,
  output logic            done,
  output logic            err
);
  localparam int NSLOT = 18;
  localparam int SLW   = $clog2(NSLOT);
  localparam logic [4:0] SP_REG = 5'd29;

  // decode
  logic [2:0] xs, sel;
  logic [3:0] acode;
  logic       is_save, reserved;
  logic [2:0] nargs, nstat;
  logic [XLEN-1:0] fsize;
  logic [NSLOT-1:0] mask_d;

  assign xs       = ext ? prefix[10:8] : 3'd0;
  assign acode    = ext ? prefix[3:0]  : 4'd0;
  assign sel      = insn[6:4];
  assign is_save  = insn[7];
  assign reserved = ext && (prefix[3:0] == 4'd15);
  assign fsize    = ext ? XLEN'({prefix[7:4], insn[3:0]}) << 3
                  : (insn[3:0] == 4'd0) ? XLEN'(128) : XLEN'(insn[3:0]) << 3;

  always_comb begin
    case (acode)
      4'd4, 4'd5, 4'd6, 4'd7: nargs = 3'd1;
      4'd8, 4'd9, 4'd10:      nargs = 3'd2;
      4'd12, 4'd13:           nargs = 3'd3;
      4'd14:                  nargs = 3'd4;
      default:                nargs = 3'd0;
    endcase
    case (acode)
      4'd1, 4'd5, 4'd9, 4'd13: nstat = 3'd1;
      4'd2, 4'd6, 4'd10:       nstat = 3'd2;
      4'd3, 4'd7:              nstat = 3'd3;
      4'd11:                   nstat = 3'd4;
      default:                 nstat = 3'd0;
    endcase
  end

  // slot map: 0-3 arg area, 4 r31, 5 r30, 6-11 r23..r18, 12 r17, 13 r16, 14-17 r7..r4
  always_comb begin
    mask_d = '0;
    for (int i = 0; i < 4; i++) begin
      mask_d[i]      = is_save && (3'(i) < nargs);
      mask_d[14 + i] = 3'(i) < nstat;
    end
    mask_d[4] = sel[2];
    mask_d[5] = xs == 3'd7;
    for (int k = 6; k < 12; k++) mask_d[k] = xs >= 3'(12 - k);
    mask_d[12] = sel[0];
    mask_d[13] = sel[1];
  end

  function automatic logic [4:0] slot_reg(input logic [SLW-1:0] s);
    if (s < 4)       return 5'(4 + s);
    else if (s == 4) return 5'd31;
    else if (s == 5) return 5'd30;
    else if (s < 12) return 5'(29 - s);
    else if (s == 12) return 5'd17;
    else if (s == 13) return 5'd16;
    else             return 5'(21 - s);
  endfunction

  // state
  logic             running, save_q, done_q, err_q;
  logic [NSLOT-1:0] mask_q;
  logic [XLEN-1:0]  sp_q, run_q, fin_q;
  logic [SLW-1:0]   cur;
  logic             any;

  always_comb begin
    cur = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (mask_q[i]) cur = SLW'(i);
  end
  assign any = |mask_q;

  assign busy      = running;
  assign done      = done_q;
  assign err       = err_q;
  assign mem_req   = running && any;
  assign mem_we    = save_q;
  assign mem_addr  = (cur < SLW'(4)) ? sp_q + (XLEN'(cur) << 2) : run_q - XLEN'(4);
  assign rf_raddr  = slot_reg(cur);
  assign mem_wdata = rf_rdata[31:0];
  assign rf_we     = running && (any ? (!save_q && mem_ready) : 1'b1);
  assign rf_waddr  = any ? slot_reg(cur) : SP_REG;
  assign rf_wdata  = any ? {{(XLEN-32){mem_rdata[31]}}, mem_rdata} : fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      save_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      mask_q  <= '0;
      sp_q    <= '0;
      run_q   <= '0;
      fin_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!running) begin
        if (start && reserved) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else if (start) begin
          running <= 1'b1;
          save_q  <= is_save;
          mask_q  <= mask_d;
          sp_q    <= sp_in;
          run_q   <= is_save ? sp_in : sp_in + fsize;
          fin_q   <= is_save ? sp_in - fsize : sp_in + fsize;
        end
      end else if (any) begin
        if (mem_ready) begin
          mask_q[cur] <= 1'b0;
          if (cur >= SLW'(4)) run_q <= run_q - XLEN'(4);
        end
      end else begin
        running <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end
endmodule

module stack_frame_seq_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ready,
  input logic [XLEN-1:0] mem_addr,
  input logic            rf_we,
  input logic [4:0]      rf_waddr
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R9
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rf_we) |-> busy);
  // R9
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R6
  sp_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && !mem_req && rf_waddr == 5'd29 |=> done);
endmodule

bind stack_frame_seq stack_frame_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .rf_we(rf_we), .rf_waddr(rf_waddr)
);

// File: tb/stack_frame_seq_tb.sv
module stack_frame_seq_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, ext = 1'b0, mem_ready = 1'b0;
  logic [15:0] prefix = '0, insn = '0;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [63:0] rf_wdata, mem_addr, sp_in, rf_rdata;
  logic [31:0] mem_wdata, mem_rdata;
  logic        rf_we, mem_req, mem_we, busy, done, err;
  logic [63:0] rf [32];

  always #2 clk = ~clk;

  assign sp_in     = rf[29];
  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = {mem_addr[2] ^ mem_addr[5], 7'h2B, mem_addr[23:0]};
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  stack_frame_seq #(.XLEN(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ext(ext), .prefix(prefix), .insn(insn),
    .sp_in(sp_in), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .busy(busy), .done(done), .err(err));

  int checks = 0, errors = 0;
  int n_exp, t_seen, sp_seen;
  bit done_seen, exp_save, exp_err;
  logic [4:0]  e_reg [18];
  logic [63:0] e_addr [18];
  logic [63:0] e_sp;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] d);
    return {{32{d[31]}}, d};
  endfunction

  function automatic logic [31:0] ld_word(input logic [63:0] a);
    return {a[2] ^ a[5], 7'h2B, a[23:0]};
  endfunction

  task automatic build(input bit x, input logic [15:0] pf, input logic [15:0] in);
    int na, ns, xc, fs;
    logic [63:0] sp, run;
    sp = rf[29];
    xc = x ? int'(pf[10:8]) : 0;
    na = 0; ns = 0;
    if (x) begin
      case (pf[3:0])
        4, 5, 6, 7: na = 1;
        8, 9, 10:   na = 2;
        12, 13:     na = 3;
        14:         na = 4;
        default:    na = 0;
      endcase
      case (pf[3:0])
        1, 5, 9, 13: ns = 1;
        2, 6, 10:    ns = 2;
        3, 7:        ns = 3;
        11:          ns = 4;
        default:     ns = 0;
      endcase
    end
    fs = x ? 8 * int'({pf[7:4], in[3:0]}) : (in[3:0] == 0 ? 128 : 8 * int'(in[3:0]));
    exp_save = in[7];
    exp_err  = x && pf[3:0] == 4'd15;
    n_exp = 0;
    if (exp_err) begin e_sp = sp; return; end
    if (exp_save) for (int i = 0; i < na; i++) begin
      e_reg[n_exp] = 5'(4 + i); e_addr[n_exp] = sp + 64'(4 * i); n_exp++;
    end
    run = exp_save ? sp : sp + 64'(fs);
    if (in[6]) begin run -= 4; e_reg[n_exp] = 5'd31; e_addr[n_exp] = run; n_exp++; end
    for (int i = 0; i < xc; i++) begin
      run -= 4;
      e_reg[n_exp] = (xc == 7 && i == 0) ? 5'd30 : 5'(23 - (i - (xc == 7 ? 1 : 0)) - (xc == 7 ? 0 : 7 - 1 - 6 + 6 - 6 + 0) + (xc == 7 ? 0 : 0) - (xc == 7 ? 0 : (6 - xc)) );
      e_addr[n_exp] = run; n_exp++;
    end
    if (in[4]) begin run -= 4; e_reg[n_exp] = 5'd17; e_addr[n_exp] = run; n_exp++; end
    if (in[5]) begin run -= 4; e_reg[n_exp] = 5'd16; e_addr[n_exp] = run; n_exp++; end
    for (int i = 0; i < ns; i++) begin
      run -= 4; e_reg[n_exp] = 5'(7 - i); e_addr[n_exp] = run; n_exp++;
    end
    e_sp = exp_save ? sp - 64'(fs) : sp + 64'(fs);
  endtask

  // monitor, samples 1 ns after the falling edge
  initial forever begin
    @(negedge clk); #1;
    if (mem_req && mem_ready) begin
      if (t_seen < n_exp) begin
        chk(mem_addr == e_addr[t_seen], "R4/R5/R7 address", mem_addr, e_addr[t_seen]);
        chk(mem_we == exp_save, "R1 direction", 64'(mem_we), 64'(exp_save));
        if (exp_save)
          chk(mem_wdata == rf[e_reg[t_seen]][31:0], "R5 store data", 64'(mem_wdata), 64'(rf[e_reg[t_seen]][31:0]));
        else
          chk(rf_we && rf_waddr == e_reg[t_seen] && rf_wdata == sx(ld_word(mem_addr)),
              "R7 load writeback", rf_wdata, sx(ld_word(mem_addr)));
      end else chk(0, "R8 extra transaction", mem_addr, 64'(n_exp));
      t_seen++;
    end
    if (rf_we && !mem_req) begin
      chk(rf_waddr == 5'd29 && rf_wdata == e_sp, "R6/R7 stack pointer write", rf_wdata, e_sp);
      sp_seen++;
    end
    if (done) done_seen = 1;
  end

  initial forever begin
    @(negedge clk);
    mem_ready = ($urandom % 3) != 0;
  end

  task automatic run_op(input bit x, input logic [15:0] pf, input logic [15:0] in);
    int wd;
    logic [63:0] sp0;
    build(x, pf, in);
    sp0 = rf[29];
    @(negedge clk);
    t_seen = 0; sp_seen = 0; done_seen = 0;
    ext = x; prefix = pf; insn = in; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(exp_err ? done : busy, "R9/R10 start response", 64'(busy), 64'(!exp_err));
    chk(exp_err ? err : 1'b1, "R10 err with done", 64'(err), 64'(exp_err));
    wd = 0;
    while (!done_seen && wd < 200) begin @(negedge clk); #2; wd++; end
    chk(done_seen, "R9 done pulse", 64'(done_seen), 64'd1);
    chk(t_seen == n_exp, "R5/R7 transaction count", 64'(t_seen), 64'(n_exp));
    chk(sp_seen == (exp_err ? 0 : 1), "R6 one sp write", 64'(sp_seen), 64'(!exp_err));
    chk(rf[29] == (exp_err ? sp0 : e_sp), "R6/R7/R10 final sp", rf[29], exp_err ? sp0 : e_sp);
    chk(!busy, "R9 idle after done", 64'(busy), 64'd0);
  endtask

  function automatic logic [15:0] mk_insn(input bit sv, input logic [2:0] sel, input logic [3:0] f);
    return {5'b01100, 3'b100, sv, sel, f};
  endfunction
  function automatic logic [15:0] mk_pf(input logic [2:0] x, input logic [3:0] hi, input logic [3:0] a);
    return {5'b11110, x, hi, a};
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
    rf[29] = 64'h0000_0000_1000_0000;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !err && !mem_req && !rf_we, "R11 reset state",
        {59'd0, busy, done, err, mem_req, rf_we}, 64'd0);
    rst_n = 1'b1;
    // R1 frame field 0 gives 128 bytes
    run_op(0, 16'h0, mk_insn(1, 3'b111, 4'd0));
    run_op(0, 16'h0, mk_insn(0, 3'b111, 4'd0));
    // R2 R3 R5 count 7 with static code 11
    run_op(1, mk_pf(3'd7, 4'd2, 4'd11), mk_insn(1, 3'b111, 4'd5));
    run_op(1, mk_pf(3'd7, 4'd2, 4'd11), mk_insn(0, 3'b111, 4'd5));
    // R4 four argument stores
    run_op(1, mk_pf(3'd0, 4'd0, 4'd14), mk_insn(1, 3'b000, 4'd0));
    // R10 reserved code
    run_op(1, mk_pf(3'd3, 4'd1, 4'd15), mk_insn(1, 3'b111, 4'd3));
    // R3 mixed codes
    run_op(1, mk_pf(3'd1, 4'd0, 4'd12), mk_insn(1, 3'b010, 4'd1));
    run_op(1, mk_pf(3'd6, 4'd0, 4'd7), mk_insn(0, 3'b001, 4'd15));
    for (int n = 0; n < 60; n++) begin
      logic [3:0] a;
      a = 4'($urandom % 15);
      if ($urandom % 2)
        run_op(1, mk_pf(3'($urandom), 4'($urandom % 4), a), mk_insn(1'($urandom), 3'($urandom), 4'($urandom)));
      else
        run_op(0, 16'($urandom), mk_insn(1'($urandom), 3'($urandom), 4'($urandom)));
    end
    run_op(1, mk_pf(3'd2, 4'd0, 4'd15), mk_insn(0, 3'b100, 4'd2));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule